// File: doc/BRIEF.md
# Discriminator Hit Pulse Former

This block sits behind sixteen discriminator channels whose hits arrive as synchronous logic levels. Each channel has an enable bit, and one veto input covers all channels. A test trigger can fire every enabled channel at once. When a channel accepts a trigger it drives an output pulse whose length in clock cycles comes from an 8-bit width code. The channel then refuses new triggers until a hold-off interval has passed. That interval is the larger of the pulse width and a separately coded dead time.

The channels form two groups. The lower half (channels 0 to 7) uses one width code and one dead-time code, and the upper half (channels 8 to 15) uses a second pair. The block also drives the OR of all channel outputs and a front-panel indicator. The indicator stays lit for a fixed number of cycles after the last output drops, so that a single short pulse can still be seen.

Top module: `hit_pulse_former`

## Requirements
- R1: Bit n of `enable_mask_i` set to 1 enables channel n, and 0 disables it. A disabled channel never starts a pulse, whether from a hit or from a test trigger. For example, mask 0xFFF3 blocks channels 2 and 3 only.
- R2: A channel starts a pulse on a 0-to-1 transition of its hit input, sampled at a clock edge while the channel is ready. Its output goes high right after that edge. A hit held high does not retrigger.
- R3: Channels 0 to 7 take their width and dead-time codes from the `_lo` ports, and channels 8 to 15 take theirs from the `_hi` ports.
- R4: A pulse lasts W(c) = 2 + (c >> 4) + 2^(c >> 5) - 1 clock cycles for width code c. This gives 2 cycles at code 0, 15 at code 100, 77 at code 200 and 144 at code 255.
- R5: The dead time for code d is D(d) = 19 + d cycles. A channel accepts its next trigger no earlier than H = max(W, D) cycles after its previous start. A trigger edge that falls inside that window is dropped, and a running pulse is never extended.
- R6: A one-cycle high on `test_strobe_i`, or a rising edge on `test_ext_i`, starts a pulse on every enabled, ready channel in the same cycle. A test input that stays high fires only once.
- R7: While `veto_i` is high, no channel starts a pulse. Trigger edges that occur during veto are lost.
- R8: `or_o` is high exactly when at least one channel output is high.
- R9: `or_led_o` is high whenever `or_o` is high and for 16 further cycles after `or_o` falls.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 16 | Per-channel discriminator hit levels |
| enable_mask_i | input | 16 | Per-channel enable, 1 = enabled |
| veto_i | input | 1 | Global veto, active high |
| test_ext_i | input | 1 | External test trigger, rising edge |
| test_strobe_i | input | 1 | Register test strobe, one cycle |
| width_code_lo_i | input | 8 | Width code for channels 0 to 7 |
| width_code_hi_i | input | 8 | Width code for channels 8 to 15 |
| dead_code_lo_i | input | 8 | Dead-time code for channels 0 to 7 |
| dead_code_hi_i | input | 8 | Dead-time code for channels 8 to 15 |
| pulse_o | output | 16 | Per-channel output pulses |
| or_o | output | 1 | OR of all channel outputs |
| or_led_o | output | 1 | Stretched OR indicator |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that a pulse can only start from a hit or test input that was high in the cycle before. They also assume that mask and veto are settled one cycle before the edge that would start a pulse. The stimulus changes every input on the falling clock edge. It changes the codes and the mask only after every channel has passed its longest hold-off, so no pulse is measured against a code that changed in the middle of that pulse.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int CODE_W     = 8;
  localparam int CNT_W      = 9;
  localparam int WIDTH_BASE = 2;
  localparam int DEAD_BASE  = 19;

  typedef logic [CNT_W-1:0]  cyc_t;
  typedef logic [CODE_W-1:0] code_t;

  // steep at the top: linear term plus power-of-two term on the top 3 bits
  function automatic cyc_t width_cycles(input code_t code);
    cyc_t lin;
    cyc_t expo;
    lin  = cyc_t'(code[CODE_W-1:CODE_W-4]);
    expo = cyc_t'(1) << code[CODE_W-1:CODE_W-3];
    return cyc_t'(WIDTH_BASE) + lin + expo - cyc_t'(1);
  endfunction

  function automatic cyc_t dead_cycles(input code_t code);
    return cyc_t'(DEAD_BASE) + cyc_t'(code);
  endfunction
endpackage

// File: rtl/code_to_cycles.sv
module code_to_cycles
  import hpf_pkg::*;
(
  input  code_t width_code_i,
  input  code_t dead_code_i,
  output cyc_t  width_cyc_o,
  output cyc_t  hold_cyc_o
);
  cyc_t w_cyc;
  cyc_t d_cyc;

  always_comb begin
    w_cyc       = width_cycles(width_code_i);
    d_cyc       = dead_cycles(dead_code_i);
    width_cyc_o = w_cyc;
    hold_cyc_o  = (w_cyc > d_cyc) ? w_cyc : d_cyc;
  end
endmodule

// File: rtl/channel_timer.sv
module channel_timer
  import hpf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic enable_i,
  input  logic veto_i,
  input  logic test_i,
  input  cyc_t width_cyc_i,
  input  cyc_t hold_cyc_i,
  output logic pulse_o
);
  logic hit_q, hit_d;
  cyc_t wcnt_q, wcnt_d;
  cyc_t hcnt_q, hcnt_d;
  logic ready, start;

  always_comb begin
    ready  = (hcnt_q == '0);
    start  = ready && enable_i && !veto_i && ((hit_i && !hit_q) || test_i);
    hit_d  = hit_i;
    if (start) begin
      wcnt_d = width_cyc_i;
      hcnt_d = hold_cyc_i - cyc_t'(1);
    end else begin
      wcnt_d = (wcnt_q != '0) ? wcnt_q - cyc_t'(1) : '0;
      hcnt_d = (hcnt_q != '0) ? hcnt_q - cyc_t'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      wcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      hit_q  <= hit_d;
      wcnt_q <= wcnt_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign pulse_o = (wcnt_q != '0);
endmodule

// File: rtl/or_stretch.sv
module or_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic or_i,
  output logic led_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (or_i)               cnt_d = CW'(HOLD);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign led_o = or_i || (cnt_q != '0);
endmodule

// File: rtl/hit_pulse_former.sv
module hit_pulse_former
  import hpf_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int OR_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic [NUM_CH-1:0] enable_mask_i,
  input  logic              veto_i,
  input  logic              test_ext_i,
  input  logic              test_strobe_i,
  input  logic [CODE_W-1:0] width_code_lo_i,
  input  logic [CODE_W-1:0] width_code_hi_i,
  input  logic [CODE_W-1:0] dead_code_lo_i,
  input  logic [CODE_W-1:0] dead_code_hi_i,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              or_o,
  output logic              or_led_o
);
  localparam int NUM_GRP    = 2;
  localparam int GROUP_SIZE = NUM_CH / NUM_GRP;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  code_t wcode [NUM_GRP];
  code_t dcode [NUM_GRP];
  cyc_t  wcyc  [NUM_GRP];
  cyc_t  hcyc  [NUM_GRP];

  assign wcode[0] = width_code_lo_i;
  assign wcode[1] = width_code_hi_i;
  assign dcode[0] = dead_code_lo_i;
  assign dcode[1] = dead_code_hi_i;

  genvar g, c;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      code_to_cycles u_cc (
        .width_code_i (wcode[g]),
        .dead_code_i  (dcode[g]),
        .width_cyc_o  (wcyc[g]),
        .hold_cyc_o   (hcyc[g])
      );
    end
  endgenerate

  // test trigger: strobe or rising edge of the external input
  logic test_ext_q, test_ext_d, test_fire;
  always_comb begin
    test_ext_d = test_ext_i;
    test_fire  = test_strobe_i || (test_ext_i && !test_ext_q);
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) test_ext_q <= 1'b0;
    else            test_ext_q <= test_ext_d;
  end

  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int GRP = c / GROUP_SIZE;
      channel_timer u_tmr (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .hit_i       (hit_i[c]),
        .enable_i    (enable_mask_i[c]),
        .veto_i      (veto_i),
        .test_i      (test_fire),
        .width_cyc_i (wcyc[GRP]),
        .hold_cyc_i  (hcyc[GRP]),
        .pulse_o     (pulse_o[c])
      );
    end
  endgenerate

  assign or_o = |pulse_o;

  or_stretch #(.HOLD(OR_HOLD)) u_led (
    .clk   (clk),
    .rst_n (rst_int_n),
    .or_i  (or_o),
    .led_o (or_led_o)
  );
endmodule

// File: rtl/hpf_checker.sv
module hpf_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] hit_i,
  input logic [NUM_CH-1:0] enable_mask_i,
  input logic              veto_i,
  input logic              test_ext_i,
  input logic              test_strobe_i,
  input logic [NUM_CH-1:0] pulse_o,
  input logic              or_o,
  input logic              or_led_o
);
  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_chk
      assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o[n]) |-> $past(enable_mask_i[n]));
      assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o[n]) |-> ($past(hit_i[n]) || $past(test_ext_i) || $past(test_strobe_i)));
      assert_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o[n]) |-> !$past(veto_i));
    end
  endgenerate

  assert_led_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    or_o |-> or_led_o);
  assert_led_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(or_o) |-> or_led_o);
endmodule

bind hit_pulse_former hpf_checker #(.NUM_CH(NUM_CH)) u_hpf_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hit_i         (hit_i),
  .enable_mask_i (enable_mask_i),
  .veto_i        (veto_i),
  .test_ext_i    (test_ext_i),
  .test_strobe_i (test_strobe_i),
  .pulse_o       (pulse_o),
  .or_o          (or_o),
  .or_led_o      (or_led_o)
);

// File: tb/tb_hit_pulse_former.sv
module tb_hit_pulse_former;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hit_i, enable_mask_i;
  logic        veto_i, test_ext_i, test_strobe_i;
  logic [7:0]  wlo, whi, dlo, dhi;
  logic [15:0] pulse_o;
  logic        or_o, or_led_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hit_pulse_former dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .enable_mask_i(enable_mask_i),
    .veto_i(veto_i), .test_ext_i(test_ext_i), .test_strobe_i(test_strobe_i),
    .width_code_lo_i(wlo), .width_code_hi_i(whi),
    .dead_code_lo_i(dlo), .dead_code_hi_i(dhi),
    .pulse_o(pulse_o), .or_o(or_o), .or_led_o(or_led_o)
  );

  function automatic int exp_w(input int c);
    return 2 + (c >> 4) + (1 << (c >> 5)) - 1;
  endfunction
  function automatic int exp_h(input int wc, input int dc);
    int w, d;
    w = exp_w(wc); d = 19 + dc;
    return (w > d) ? w : d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_codes(input int a, input int b, input int c, input int d);
    @(negedge clk);
    wlo = 8'(a); whi = 8'(b); dlo = 8'(c); dhi = 8'(d);
  endtask

  // drive a hit edge on mask now; again at step retrig; count highs of channel ch
  task automatic run_window(input logic [15:0] mask, input int ch, input int retrig,
                            input int n, output int cnt);
    cnt = 0;
    hit_i = mask;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (pulse_o[ch]) cnt++;
      hit_i = (j == retrig) ? mask : 16'h0;
    end
    hit_i = 16'h0;
  endtask

  task automatic t_reset();
    check(pulse_o == 16'h0, "R10 pulses", int'(pulse_o), 0);
    check(or_o == 1'b0, "R10 or", int'(or_o), 0);
    check(or_led_o == 1'b0, "R10 led", int'(or_led_o), 0);
  endtask

  task automatic t_width();
    int cnt;
    set_codes(0, 255, 0, 0);
    run_window(16'h0001, 0, 0, 200, cnt);
    check(cnt == exp_w(0), "R4 code0 ch0", cnt, exp_w(0));
    run_window(16'h0200, 9, 0, 200, cnt);
    check(cnt == exp_w(255), "R4 R3 code255 ch9", cnt, exp_w(255));
    settle(300);
    set_codes(100, 0, 0, 0);
    run_window(16'h0008, 3, 0, 100, cnt);
    check(cnt == exp_w(100), "R4 code100 ch3", cnt, exp_w(100));
    run_window(16'h8000, 15, 0, 100, cnt);
    check(cnt == exp_w(0), "R3 hi group ch15", cnt, exp_w(0));
    settle(300);
  endtask

  task automatic t_hold();
    int cnt, h;
    set_codes(0, 0, 10, 0);
    h = exp_h(0, 10);
    run_window(16'h0002, 1, h - 1, 100, cnt);
    check(cnt == 2, "R5 edge inside dead time dropped", cnt, 2);
    settle(300);
    run_window(16'h0002, 1, h, 100, cnt);
    check(cnt == 4, "R5 edge at dead time end accepted", cnt, 4);
    settle(300);
    set_codes(200, 0, 0, 0);
    h = exp_h(200, 0);
    run_window(16'h0004, 2, h - 1, 300, cnt);
    check(cnt == h, "R5 width dominates, early edge dropped", cnt, h);
    settle(300);
    run_window(16'h0004, 2, h, 300, cnt);
    check(cnt == 2 * h, "R5 width dominates, retrigger at end", cnt, 2 * h);
    settle(300);
  endtask

  task automatic t_mask();
    int cnt;
    set_codes(0, 0, 0, 0);
    enable_mask_i = 16'hFFF3;
    hit_i = 16'hFFFF;
    @(negedge clk);
    check(pulse_o == 16'hFFF3, "R1 R2 mask FFF3", int'(pulse_o), 16'hFFF3);
    settle(40);
    check(pulse_o == 16'h0, "R2 held hit no retrigger", int'(pulse_o), 0);
    hit_i = 16'h0;
    settle(5);
    run_window(16'h0004, 2, 0, 40, cnt);
    check(cnt == 0, "R1 disabled ch2 silent", cnt, 0);
    enable_mask_i = 16'hFFFF;
    settle(40);
  endtask

  task automatic t_test();
    int cnt;
    enable_mask_i = 16'h00FF;
    test_strobe_i = 1'b1;
    @(negedge clk);
    test_strobe_i = 1'b0;
    check(pulse_o == 16'h00FF, "R6 strobe fires enabled", int'(pulse_o), 16'h00FF);
    settle(40);
    enable_mask_i = 16'hA5A5;
    cnt = 0;
    test_ext_i = 1'b1;
    for (int j = 0; j < 60; j++) begin
      @(negedge clk);
      if (j == 0) check(pulse_o == 16'hA5A5, "R6 ext edge fires enabled", int'(pulse_o), 16'hA5A5);
      if (pulse_o[0]) cnt++;
    end
    test_ext_i = 1'b0;
    check(cnt == exp_w(0), "R6 held test fires once", cnt, exp_w(0));
    enable_mask_i = 16'hFFFF;
    settle(40);
  endtask

  task automatic t_veto();
    int cnt;
    veto_i = 1'b1;
    @(negedge clk);
    run_window(16'hFFFF, 4, 0, 30, cnt);
    check(cnt == 0, "R7 veto blocks hit", cnt, 0);
    hit_i = 16'h0010;
    settle(2);
    veto_i = 1'b0;
    settle(5);
    check(pulse_o == 16'h0, "R7 edge during veto lost", int'(pulse_o), 0);
    hit_i = 16'h0;
    settle(2);
    run_window(16'h0010, 4, 0, 30, cnt);
    check(cnt == exp_w(0), "R7 after veto hit fires", cnt, exp_w(0));
    settle(40);
  endtask

  task automatic t_or();
    int led_cnt;
    bit or_ok;
    led_cnt = 0; or_ok = 1;
    hit_i = 16'h0020;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      hit_i = 16'h0;
      if (or_o != (pulse_o != 16'h0)) or_ok = 0;
      if (or_led_o) led_cnt++;
    end
    check(or_ok, "R8 or matches outputs", int'(or_ok), 1);
    check(led_cnt == exp_w(0) + 16, "R9 led stretch", led_cnt, exp_w(0) + 16);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    hit_i = '0; enable_mask_i = 16'hFFFF; veto_i = 0; test_ext_i = 0; test_strobe_i = 0;
    wlo = 0; whi = 0; dlo = 0; dhi = 0;
    settle(4);
    rst_n = 1'b1;
    settle(4);
    t_reset();
    t_width();
    t_hold();
    t_mask();
    t_test();
    t_veto();
    t_or();
    finish_run();
  end
endmodule